// File: doc/BRIEF.md
# Oversampling ADC Measurement Sequencer

This block steps one analog-to-digital converter through a list of up to eight measurement slots. Software programs each slot with a trigger code, an input channel, an oversample count and a result offset, selects which slots take part through an enable mask, and sets a run bit. At that moment the mask, the base address and all slot words are frozen into shadow copies. Later register writes change only the live copies, so software can prepare the next sequence while the current one runs.

Enabled slots are visited in ascending slot number. For each slot the sequencer waits for the slot's trigger and then performs oversample+1 conversions. Only the first conversion waits for the trigger. For every conversion the channel select is raised one cycle before the start-of-conversion pulse and is dropped again after the converter reports its data. The conversion results are summed. The finished sum is written out on a write-request port, together with an address computed from the base and the slot's offset. A current-result register follows the running sum. A last-result register keeps the most recent finished sum. A status field reports the active slot.

In single mode the run bit clears itself after one pass through the enabled slots. In continuous mode the passes repeat until software clears the run bit, which also aborts any conversion in progress.

Top module: `adc_seq`

## Requirements
- R1: After reset, status reads 8 (idle), the control word reads 0, and `adc_mux`, `adc_soc` and `wr_valid` are low.
- R2: Only slots whose bit is set in the enable mask (register 1, bits 7:0) are measured, one result per enabled slot per pass, in ascending slot order.
- R3: Each slot word (registers 8..15 for slots 0..7) carries the oversample count n in bits 19:17. A slot performs n+1 conversions, and its result is the sum of their data.
- R4: The trigger code sits in bits 16:0. Codes below 0x10000 fire when `evt_count` equals the code. A code of 0x10000+k fires when `evt_strobe[k]` is high. Only the first conversion of a slot waits for its trigger.
- R5: The channel select in bits 22:20 drives the one-hot `adc_mux` one cycle before `adc_soc` and for the rest of the conversion. `adc_mux` is low for at least one cycle between conversions.
- R6: The result address is the base (register 2) with bit 0 cleared, plus twice the offset in bits 27:23. In wide mode (control bit 2) it is the base with bits 1:0 cleared, plus four times the offset.
- R7: Writing control bit 0 = 1 while idle starts a pass. In single mode (control bit 1 = 0) the run bit reads 0 again and status returns to 8 after the pass.
- R8: In continuous mode the passes repeat. Writing control bit 0 = 0 stops the sequencer within one cycle, with `adc_mux` and `adc_soc` low and status 8.
- R9: Writes to the mask and slot registers during a run do not change the running sequence.
- R10: A result word holds the sum in bits 14:0, the slot in bits 18:16 and a final flag in bit 31. The current result (register 4) shows partial sums with bit 31 = 0, then the final sum with bit 31 = 1. The last result (register 5) equals the last emitted word.
- R11: With write disable set (control bit 3), no `wr_valid` is produced and the last-result register keeps its value, while the current result still completes.
- R12: Status (register 3) reads the active slot number while running and 8 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| evt_count | input | 16 | External event counter value |
| evt_strobe | input | NEVT | External event trigger lines |
| adc_mux | output | 8 | One-hot input channel select |
| adc_soc | output | 1 | Start-of-conversion pulse |
| adc_done | input | 1 | Converter data valid pulse |
| adc_data | input | DATA_W | Conversion result |
| wr_valid | output | 1 | Result write request, one cycle |
| wr_addr | output | 32 | Result byte address |
| wr_data | output | 32 | Result word |
| wr_wide | output | 1 | Write uses full-word access |

## Verification
The assertions assume that the converter answers each `adc_soc` with exactly one `adc_done` pulse, at least one cycle later. They also assume that `adc_done` arriving while idle or waiting is harmless. The bench converter model keeps to this by arming a fixed two-cycle latency only on a start pulse. It then feeds random data that the bench sums independently. Random slot setups use strobe-style triggers held active, so passes end quickly. One directed case holds the event counter away from the trigger value to show the wait, then moves it past the value in one cycle, which shows that the later conversions do not wait.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DATA_W = 12,
  parameter int NEVT   = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [15:0]       evt_count,
  input  logic [NEVT-1:0]   evt_strobe,
  output logic [7:0]        adc_mux,
  output logic              adc_soc,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              wr_valid,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  output logic              wr_wide
);
  localparam int NSLOT = 8;
  localparam int SUM_W = DATA_W + 3;
  localparam int EW    = (NEVT > 1) ? $clog2(NEVT) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SEEK, S_TRIG, S_MUX, S_SOC, S_CONV, S_GAP} st_t;
  st_t st;

  logic              run_q, cont_q, wide_q, dis_q, wide_s, dis_s;
  logic [7:0]        en_q, en_s;
  logic [31:0]       base_q, base_s;
  logic [27:0]       slot_q [NSLOT];
  logic [27:0]       slot_s [NSLOT];
  logic [3:0]        ptr;
  logic [2:0]        cur, cnt;
  logic [SUM_W-1:0]  acc;
  logic [31:0]       res_cur, res_last;

  logic        nxt_found;
  logic [2:0]  nxt_idx;
  always_comb begin
    nxt_found = 1'b0;
    nxt_idx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (en_s[i] && (4'(i) >= ptr)) begin
        nxt_found = 1'b1;
        nxt_idx   = 3'(i);
      end
  end

  wire [27:0]      sel    = slot_s[cur];
  wire [16:0]      code   = sel[16:0];
  wire [2:0]       ovs    = sel[19:17];
  wire [2:0]       chan   = sel[22:20];
  wire [4:0]       off    = sel[27:23];
  wire             strobe_ok = (code[15:0] < 16'(NEVT)) && evt_strobe[code[EW-1:0]];
  wire             trig_hit  = code[16] ? strobe_ok : (evt_count == code[15:0]);
  wire [SUM_W-1:0] sum_n  = acc + SUM_W'(adc_data);
  wire             final_s = (cnt == ovs);
  wire [31:0]      word_n = {final_s, 12'b0, cur, 1'b0, 15'(sum_n)};
  wire [31:0]      addr_n = wide_s ? ({base_s[31:2], 2'b00} + {25'b0, off, 2'b00})
                                   : ({base_s[31:1], 1'b0}  + {26'b0, off, 1'b0});
  wire             ctl_wr = reg_wr && (reg_addr == 4'd0);
  wire             start  = ctl_wr && reg_wdata[0] && (st == S_IDLE);
  wire             stop   = ctl_wr && !reg_wdata[0];

  assign adc_mux = (st == S_MUX || st == S_SOC || st == S_CONV) ? (8'd1 << chan) : 8'd0;
  assign adc_soc = (st == S_SOC);
  assign wr_wide = wide_s;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[3]) reg_rdata = {4'b0, slot_q[reg_addr[2:0]]};
    else case (reg_addr[2:0])
      3'd0: reg_rdata = {28'b0, dis_q, wide_q, cont_q, run_q};
      3'd1: reg_rdata = {24'b0, en_q};
      3'd2: reg_rdata = base_q;
      3'd3: reg_rdata = {28'b0, (st == S_IDLE) ? 4'd8 : {1'b0, cur}};
      3'd4: reg_rdata = res_cur;
      3'd5: reg_rdata = res_last;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {run_q, cont_q, wide_q, dis_q, wide_s, dis_s} <= '0;
      en_q <= '0; en_s <= '0; base_q <= '0; base_s <= '0;
      for (int i = 0; i < NSLOT; i++) begin slot_q[i] <= '0; slot_s[i] <= '0; end
      ptr <= '0; cur <= '0; cnt <= '0; acc <= '0;
      res_cur <= '0; res_last <= '0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (reg_wr) begin
        if (reg_addr[3]) slot_q[reg_addr[2:0]] <= reg_wdata[27:0];
        else case (reg_addr[2:0])
          3'd0: {dis_q, wide_q, cont_q} <= reg_wdata[3:1];
          3'd1: en_q   <= reg_wdata[7:0];
          3'd2: base_q <= reg_wdata;
          default: ;
        endcase
      end
      if (start) begin
        en_s <= en_q; base_s <= base_q; wide_s <= reg_wdata[2]; dis_s <= reg_wdata[3];
        for (int i = 0; i < NSLOT; i++) slot_s[i] <= slot_q[i];
      end
      if (stop) begin
        st <= S_IDLE;
        run_q <= 1'b0;
      end else begin
        if (start) run_q <= 1'b1;
        case (st)
          S_IDLE: if (start) begin st <= S_SEEK; ptr <= '0; end
          S_SEEK: begin
            if (nxt_found) begin
              cur <= nxt_idx; cnt <= '0; acc <= '0;
              res_cur <= {16'b0, 1'b0, nxt_idx, 16'b0} >> 0;
              st <= S_TRIG;
            end else if (cont_q) begin
              ptr <= '0;
            end else begin
              st <= S_IDLE;
              run_q <= 1'b0;
            end
          end
          S_TRIG: if (trig_hit) st <= S_MUX;
          S_MUX:  st <= S_SOC;
          S_SOC:  st <= S_CONV;
          S_CONV: if (adc_done) begin
            acc <= sum_n;
            res_cur <= word_n;
            if (final_s) begin
              ptr <= {1'b0, cur} + 4'd1;
              st  <= S_SEEK;
              if (!dis_s) begin
                res_last <= word_n;
                wr_valid <= 1'b1;
                wr_addr  <= addr_n;
                wr_data  <= word_n;
              end
            end else begin
              cnt <= cnt + 3'd1;
              st  <= S_GAP;
            end
          end
          S_GAP:  st <= S_MUX;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_mux_before_soc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_soc) |-> (adc_mux != 8'd0 && $past(adc_mux) == adc_mux));
  a_r5_mux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_mux));
  a_r3_emit_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(adc_done));
  a_r6_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_wide ? (wr_addr[1:0] == 2'b00) : (wr_addr[0] == 1'b0)));
  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd0 && !reg_wdata[0]) |=> (adc_mux == 8'd0 && !adc_soc && !wr_valid));
  a_r10_emit_final: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[31]);
endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] evt_count = '0;
  logic [15:0] evt_strobe = '0;
  logic [7:0] adc_mux;
  logic adc_soc, adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic wr_valid, wr_wide;
  logic [31:0] wr_addr, wr_data;

  always #2 clk = ~clk;

  adc_seq u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_count(evt_count),
    .evt_strobe(evt_strobe), .adc_mux(adc_mux), .adc_soc(adc_soc), .adc_done(adc_done),
    .adc_data(adc_data), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_wide(wr_wide));

  int n_chk = 0, n_fail = 0;
  logic [7:0]  bm_mask;
  logic [27:0] bm_slot [8];
  logic [31:0] bm_base;
  logic        bm_wide;
  int b_acc, b_nsamp, b_nwr, b_nsoc, b_pass, b_lat;
  int b_nxt;
  logic [31:0] b_last;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic int next_en(input logic [7:0] m, input int from);
    for (int i = from; i < 8; i++) if (m[i]) return i;
    return 8;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [4:0] o, input logic w);
    return w ? ({b[31:2], 2'b00} + 32'(o) * 4) : ({b[31:1], 1'b0} + 32'(o) * 2);
  endfunction

  initial begin : bfm
    b_lat = 0;
    forever begin
      @(negedge clk);
      if (wr_valid) begin
        logic [27:0] s;
        s = bm_slot[b_nxt[2:0]];
        chk(b_nsamp == int'(s[19:17]) + 1, "R3 sample count", b_nsamp, int'(s[19:17]) + 1);
        chk(wr_data == {1'b1, 12'b0, b_nxt[2:0], 1'b0, 15'(b_acc)}, "R2/R3/R10 result word",
            wr_data, {1'b1, 12'b0, b_nxt[2:0], 1'b0, 15'(b_acc)});
        chk(wr_addr == exp_addr(bm_base, s[27:23], bm_wide), "R6 address", wr_addr,
            exp_addr(bm_base, s[27:23], bm_wide));
        b_last = wr_data; b_acc = 0; b_nsamp = 0; b_nwr++;
        b_nxt = next_en(bm_mask, b_nxt + 1);
        if (b_nxt == 8) begin b_pass++; b_nxt = next_en(bm_mask, 0); end
      end
      if (adc_done) adc_done = 1'b0;
      if (b_lat > 0) begin
        b_lat--;
        if (b_lat == 0) begin
          adc_data = 12'($urandom % 4096);
          adc_done = 1'b1;
          b_acc += int'(adc_data);
          b_nsamp++;
        end
      end
      if (adc_soc) begin
        b_nsoc++;
        if (b_nxt < 8)
          chk(adc_mux == (8'd1 << bm_slot[b_nxt[2:0]][22:20]), "R5 mux at soc", adc_mux,
              8'd1 << bm_slot[b_nxt[2:0]][22:20]);
        b_lat = 2;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cfg(input logic [7:0] m, input logic [31:0] b);
    bm_mask = m; bm_base = b;
    wreg(4'd1, {24'b0, m}); wreg(4'd2, b);
  endtask

  task automatic cfg_slot(input int i, input logic [27:0] w);
    bm_slot[i] = w; wreg(4'(8 + i), {4'b0, w});
  endtask

  task automatic bench_clear;
    b_acc = 0; b_nsamp = 0; b_nwr = 0; b_nsoc = 0; b_pass = 0;
    b_nxt = next_en(bm_mask, 0);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] d;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk); rreg(4'd3, d);
      if (d == 32'd8) return;
    end
    chk(0, tag, 0, 8);
  endtask

  initial begin : main
    logic [31:0] d, lastv;
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < 8; i++) bm_slot[i] = '0;
    bm_mask = '0; bm_base = '0; bm_wide = 0; b_last = '0;
    bench_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rreg(4'd3, d); chk(d == 32'd8, "R1 status idle", d, 8);
    rreg(4'd0, d); chk(d == 32'd0, "R1 control zero", d, 0);
    chk(adc_mux == 0 && !adc_soc && !wr_valid, "R1 outputs low", {adc_mux, adc_soc, wr_valid}, 0);

    // R4 / R9 / R10: counter trigger, shadowing, partial result
    evt_count = 16'd0; evt_strobe = '0;
    cfg_slot(0, {5'd3, 3'd5, 3'd3, 17'h00020});
    cfg(8'h01, 32'h0000_1000); bm_wide = 0;
    bench_clear();
    wreg(4'd0, 32'h1);
    repeat (30) @(negedge clk);
    chk(b_nsoc == 0, "R4 waits for trigger", b_nsoc, 0);
    rreg(4'd3, d); chk(d == 32'd0, "R12 status active slot", d, 0);
    wreg(4'd8, {4'b0, 5'd9, 3'd1, 3'd0, 17'h10000});
    wreg(4'd1, 32'hFF);
    @(negedge clk); evt_count = 16'd32;
    @(negedge clk); evt_count = 16'd33;
    while (b_nsamp < 1) @(negedge clk);
    repeat (2) @(negedge clk);
    rreg(4'd4, d);
    chk(d == {1'b0, 12'b0, 3'd0, 1'b0, 15'(b_acc)}, "R10 partial current", d,
        {1'b0, 12'b0, 3'd0, 1'b0, 15'(b_acc)});
    wait_idle("R7 single pass ends");
    chk(b_nsoc == 4, "R4 later conversions untriggered", b_nsoc, 4);
    chk(b_nwr == 1, "R9 shadowed config", b_nwr, 1);
    rreg(4'd5, d); chk(d == b_last, "R10 last result", d, b_last);
    rreg(4'd0, d); chk(d[0] == 1'b0, "R7 run cleared", d[0], 0);

    // R2 / R3 / R6 random sequences
    evt_strobe = 16'hFFFF;
    for (int t = 0; t < 20; t++) begin
      logic [7:0] m;
      m = 8'($urandom % 255 + 1);
      bm_wide = t[0];
      for (int i = 0; i < 8; i++)
        cfg_slot(i, {5'($urandom), 3'($urandom), 3'($urandom), 17'h10000 | 17'($urandom % 4)});
      cfg(m, $urandom);
      bench_clear();
      wreg(4'd0, {29'b0, bm_wide, 2'b01});
      wait_idle("R7 random pass ends");
      chk(b_nwr == $countones(m), "R2 one result per enabled slot", b_nwr, $countones(m));
      rreg(4'd5, d); chk(d == b_last, "R10 last matches emitted", d, b_last);
      rreg(4'd0, d); chk(d[0] == 1'b0, "R7 run self-clears", d[0], 0);
    end

    // R8 continuous and abort
    bm_wide = 0;
    cfg_slot(0, {5'd1, 3'd2, 3'd0, 17'h10001});
    cfg_slot(2, {5'd4, 3'd6, 3'd0, 17'h10002});
    cfg(8'h05, 32'h0000_2000);
    bench_clear();
    wreg(4'd0, 32'h3);
    while (b_pass < 3) @(negedge clk);
    wreg(4'd0, 32'h2);
    rreg(4'd3, d); chk(d == 32'd8, "R8 stop to idle", d, 8);
    chk(adc_mux == 0 && !adc_soc, "R8 stop releases adc", {adc_mux, adc_soc}, 0);
    begin
      int w0;
      w0 = b_nwr;
      repeat (20) @(negedge clk);
      chk(b_nwr == w0, "R8 no writes after stop", b_nwr, w0);
    end

    // R11 write disable
    rreg(4'd5, lastv);
    cfg_slot(1, {5'd7, 3'd3, 3'd1, 17'h10000});
    cfg(8'h02, 32'h0000_3000);
    bench_clear();
    wreg(4'd0, 32'h9);
    wait_idle("R11 disabled pass ends");
    chk(b_nwr == 0, "R11 no write requests", b_nwr, 0);
    rreg(4'd4, d);
    chk(d == {1'b1, 12'b0, 3'd1, 1'b0, 15'(b_acc)}, "R11 current completes", d,
        {1'b1, 12'b0, 3'd1, 1'b0, 15'(b_acc)});
    rreg(4'd5, d); chk(d == lastv, "R11 last kept", d, lastv);

    report();
  end
endmodule